// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Trigger Capture

This block buffers packed X/Y/Z measurement samples in a 32-entry memory for a host that reads them in bursts. A single 8-bit control word picks one of four operating modes: a direct path with no buffering, fill-and-stop, streaming overwrite, and trigger capture. The same word also holds a watermark level and a routing bit that steers the trigger indication onto one of two interrupt lines.

Samples arrive with a valid strobe. The host takes the oldest entry from the output word and pops it. The entry count, watermark flag, overrun flag and trigger status are registered outputs.

In trigger capture mode the buffer behaves like a ring until a trigger event arrives. After the event it trims itself, one entry per cycle, down to the newest n entries, where n is the watermark level. It then fills without overwriting. A busy flag covers the trim, and pops are ignored while busy is high.

Top module: `axis3_sample_fifo`

## Requirements
- R1: The control word is split into three fields: cfg_i[7:6] is the mode (00 direct, 01 fill-and-stop, 10 stream, 11 trigger capture), cfg_i[5] is the routing bit, and cfg_i[4:0] is the level. After reset the mode is direct and the level is 0, and count_o, data_o, wmark_o, overrun_o, trig_done_o, busy_o and trig_irq_o are all zero.
- R2: In direct mode count_o stays 0, and each valid sample appears on data_o one cycle later. overrun_o sets when a sample replaces one that has not been popped since it arrived. A pop clears both overrun_o and the unread state.
- R3: In fill-and-stop mode samples are stored in arrival order up to 32 entries. Later samples are dropped, and pops return entries oldest first.
- R4: In stream mode a sample arriving at a full buffer discards the oldest entry, so the buffer holds the newest 32 samples.
- R5: Outside direct mode wmark_o is high while count_o is at or above the level, so a level of 0 keeps it high. In direct mode wmark_o is low.
- R6: Outside direct mode overrun_o sets when a stored sample brings count_o to 32. Any accepted pop clears it.
- R7: In trigger capture mode the first trigger pulse sets trig_done_o. The buffer then keeps only the newest n entries (n is the level) and from then on follows fill-and-stop rules.
- R8: After a trigger that finds count_o above n, busy_o is high for exactly count_o minus n cycles, starting the cycle after the trigger. Pops during those cycles are ignored.
- R9: Once trig_done_o is set, further trigger pulses have no effect. Any write that changes the mode empties the buffer and clears the trigger status and overrun_o, which re-arms trigger capture after a detour through another mode.
- R10: A control write that keeps the current mode updates only the level and the routing bit. Stored entries and count_o are kept.
- R11: trig_irq_o carries trig_done_o on bit 0 when the routing bit is 0 and on bit 1 when it is 1. The other bit stays 0.
- R12: A sample and a pop in the same cycle both take effect, including in fill-and-stop mode at 32 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_i | input | 8 | Control word: mode, routing bit, level |
| smp_valid_i | input | 1 | Sample valid strobe |
| smp_data_i | input | 48 | Packed X/Y/Z sample |
| trig_i | input | 1 | Trigger event pulse |
| pop_i | input | 1 | Pop request for the oldest entry |
| data_o | output | 48 | Oldest entry, or the held sample in direct mode |
| count_o | output | 6 | Number of stored entries |
| wmark_o | output | 1 | Watermark flag |
| overrun_o | output | 1 | Overrun flag |
| trig_done_o | output | 1 | Trigger has been captured |
| busy_o | output | 1 | Post-trigger trim in progress |
| trig_irq_o | output | 2 | Trigger indication on the selected line |

## Verification
The hardest state to reach is a trim in progress with a pop arriving during it, and then a second trigger after the buffer has refilled. To get there, the bench streams twenty samples in trigger mode and fires the trigger. It raises a pop on the first busy cycle and counts the busy cycles against the expected 15. It then refills the buffer to 32 and fires a second trigger, which must change nothing. A detour through direct mode re-arms the capture, and the bench checks it again with the other routing value.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'b00,
    MODE_FILL = 2'b01,
    MODE_STRM = 2'b10,
    MODE_TRIG = 2'b11
  } sfifo_mode_e;

  localparam int unsigned CfgModeHi = 7;
  localparam int unsigned CfgModeLo = 6;
  localparam int unsigned CfgRoute  = 5;
endpackage

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [PTR_W-1:0] rptr_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wptr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_i];
endmodule

// File: rtl/sfifo_trim.sv
module sfifo_trim #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] left_q;

  assign busy_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (clr_i)  left_q <= '0;
    else if (load_i) left_q <= load_val_i;
    else if (busy_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/sfifo_hold.sv
module sfifo_hold #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] data_o,
  output logic         ovr_o
);
  logic unread_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      unread_q <= 1'b0;
      ovr_o    <= 1'b0;
    end else if (clr_i) begin
      data_o   <= '0;
      unread_q <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      if (wr_i) begin
        data_o   <= wdata_i;
        unread_q <= 1'b1;
      end else if (rd_i) begin
        unread_q <= 1'b0;
      end
      if (rd_i)                  ovr_o <= 1'b0;
      else if (wr_i && unread_q) ovr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/axis3_sample_fifo.sv
module axis3_sample_fifo
  import sfifo_pkg::*;
#(
  parameter int unsigned AXIS_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned SMP_W = 3 * AXIS_W,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             trig_i,
  input  logic             pop_i,
  output logic [SMP_W-1:0] data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wmark_o,
  output logic             overrun_o,
  output logic             trig_done_o,
  output logic             busy_o,
  output logic [1:0]       trig_irq_o
);
  sfifo_mode_e      mode_q;
  logic [PTR_W-1:0] level_q;
  logic             route_q;
  logic [CNT_W-1:0] count_q, count_nxt, lvl_ext, drop_val;
  logic [PTR_W-1:0] rd_q, wr_q;
  logic             trig_q, ovr_q;

  sfifo_mode_e cfg_mode;
  logic mode_chg, byp, eff_strm, full, trim;
  logic pop_ok, push_ok, strm_drop, adv_rd, fire;
  logic [SMP_W-1:0] mem_rdata, hold_data;
  logic hold_ovr;

  assign cfg_mode = sfifo_mode_e'(cfg_i[CfgModeHi:CfgModeLo]);
  assign mode_chg = cfg_we_i && (cfg_mode != mode_q);
  assign byp      = (mode_q == MODE_BYP);
  assign eff_strm = (mode_q == MODE_STRM) || (mode_q == MODE_TRIG && !trig_q);
  assign full     = (count_q == CNT_W'(DEPTH));
  assign lvl_ext  = {1'b0, level_q};
  assign trim     = busy_o;

  assign pop_ok    = pop_i && !byp && !mode_chg && !trim && (count_q != '0);
  // fill-and-stop accepts at full only if a slot frees this cycle
  assign push_ok   = smp_valid_i && !byp && !mode_chg &&
                     (eff_strm || !full || pop_ok || trim);
  assign strm_drop = push_ok && eff_strm && full && !pop_ok;
  assign adv_rd    = pop_ok || strm_drop || trim;
  assign count_nxt = count_q + CNT_W'(push_ok) - CNT_W'(adv_rd);

  assign fire     = trig_i && (mode_q == MODE_TRIG) && !trig_q && !mode_chg;
  assign drop_val = (count_q > lvl_ext) ? (count_q - lvl_ext) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_BYP;
      level_q <= '0;
      route_q <= 1'b0;
      count_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      trig_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (mode_chg) begin
      mode_q  <= cfg_mode;
      level_q <= cfg_i[PTR_W-1:0];
      route_q <= cfg_i[CfgRoute];
      count_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      trig_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        level_q <= cfg_i[PTR_W-1:0];
        route_q <= cfg_i[CfgRoute];
      end
      count_q <= count_nxt;
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (adv_rd)  rd_q <= rd_q + 1'b1;
      if (fire)    trig_q <= 1'b1;
      if (pop_ok)                                        ovr_q <= 1'b0;
      else if (push_ok && count_nxt == CNT_W'(DEPTH))    ovr_q <= 1'b1;
    end
  end

  sfifo_mem #(.W(SMP_W), .DEPTH(DEPTH)) i_mem (
    .clk_i   (clk_i),
    .we_i    (push_ok),
    .wptr_i  (wr_q),
    .wdata_i (smp_data_i),
    .rptr_i  (rd_q),
    .rdata_o (mem_rdata)
  );

  sfifo_trim #(.CNT_W(CNT_W)) i_trim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (mode_chg),
    .load_i     (fire),
    .load_val_i (drop_val),
    .busy_o     (busy_o)
  );

  sfifo_hold #(.W(SMP_W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_chg),
    .wr_i    (smp_valid_i && byp && !mode_chg),
    .rd_i    (pop_i && byp && !mode_chg),
    .wdata_i (smp_data_i),
    .data_o  (hold_data),
    .ovr_o   (hold_ovr)
  );

  assign data_o      = byp ? hold_data : ((count_q != '0) ? mem_rdata : '0);
  assign count_o     = count_q;
  assign wmark_o     = !byp && (count_q >= lvl_ext);
  assign overrun_o   = byp ? hold_ovr : ovr_q;
  assign trig_done_o = trig_q;
  assign trig_irq_o  = route_q ? {trig_q, 1'b0} : {1'b0, trig_q};
endmodule

// File: rtl/axis3_sample_fifo_chk.sv
module axis3_sample_fifo_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] count_o,
  input logic             wmark_o,
  input logic             overrun_o,
  input logic             trig_done_o,
  input logic             busy_o,
  input logic [1:0]       trig_irq_o,
  input logic [1:0]       mode_q,
  input logic [PTR_W-1:0] level_q
);
  AST_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)); // R3

  AST_BYP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00) |-> (count_o == '0)); // R2

  AST_WMARK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wmark_o) && !$past(cfg_we_i)) |-> (count_o == {1'b0, level_q})); // R5

  AST_OVR_POP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 2'b00 && pop_i && count_o != '0 && !busy_o && !cfg_we_i)
      |=> !overrun_o); // R6

  AST_BUSY_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> trig_done_o); // R8

  AST_TRIG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_done_o && !cfg_we_i) |=> trig_done_o); // R9

  AST_IRQ_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trig_irq_o) && ($countones(trig_irq_o) == 32'(trig_done_o))); // R11
endmodule

bind axis3_sample_fifo axis3_sample_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .pop_i       (pop_i),
  .count_o     (count_o),
  .wmark_o     (wmark_o),
  .overrun_o   (overrun_o),
  .trig_done_o (trig_done_o),
  .busy_o      (busy_o),
  .trig_irq_o  (trig_irq_o),
  .mode_q      (mode_q),
  .level_q     (level_q)
);

// File: tb/test_axis3_sample_fifo.sv
`timescale 1ns/1ps
module test_axis3_sample_fifo;
  localparam logic [1:0] M_BYP = 2'b00, M_FILL = 2'b01, M_STRM = 2'b10, M_TRIG = 2'b11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [47:0] smp_data_i = '0;
  logic        trig_i = 1'b0;
  logic        pop_i = 1'b0;
  logic [47:0] data_o;
  logic [5:0]  count_o;
  logic        wmark_o, overrun_o, trig_done_o, busy_o;
  logic [1:0]  trig_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  axis3_sample_fifo i_axis3_sample_fifo (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic cfg(input logic [1:0] m, input bit route, input int lvl);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_i = {m, route, 5'(lvl)};
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic push(input longint v);
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_data_i = 48'(v);
    @(negedge clk_i);
    smp_valid_i = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk_i);
    pop_i = 1'b1;
    @(negedge clk_i);
    pop_i = 1'b0;
  endtask

  task automatic push_pop(input longint v);
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_data_i = 48'(v); pop_i = 1'b1;
    @(negedge clk_i);
    smp_valid_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic trigger();
    @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
  endtask

  task automatic t_reset();
    eq("R1", "count", count_o, 0);
    eq("R1", "data", data_o, 0);
    eq("R1", "flags", {wmark_o, overrun_o, trig_done_o, busy_o}, 0);
    eq("R1", "irq", trig_irq_o, 0);
  endtask

  task automatic t_bypass();
    push(48'h111);
    eq("R2", "direct data", data_o, 48'h111);
    eq("R2", "direct count", count_o, 0);
    eq("R2", "no overrun first", overrun_o, 0);
    eq("R5", "wmark low in direct", wmark_o, 0);
    push(48'h222);
    eq("R2", "replaced data", data_o, 48'h222);
    eq("R2", "overrun on unread", overrun_o, 1);
    pop();
    eq("R2", "overrun cleared by pop", overrun_o, 0);
    push(48'h333);
    eq("R2", "no overrun after read", overrun_o, 0);
  endtask

  task automatic t_fill();
    cfg(M_FILL, 1'b0, 4);
    eq("R9", "mode change empties", count_o, 0);
    for (int i = 1; i <= 31; i++) push(i);
    eq("R6", "no overrun at 31", overrun_o, 0);
    push(32);
    eq("R3", "count at full", count_o, 32);
    eq("R6", "overrun at full", overrun_o, 1);
    push(33); push(34);
    eq("R3", "count capped", count_o, 32);
    eq("R3", "oldest kept", data_o, 1);
    for (int k = 1; k <= 32; k++) begin
      eq("R3", "pop order", data_o, k);
      pop();
      if (k == 1) eq("R6", "overrun cleared by pop", overrun_o, 0);
    end
    eq("R3", "drained, extras dropped", count_o, 0);
  endtask

  task automatic t_wmark();
    cfg(M_FILL, 1'b0, 4);
    for (int i = 0; i < 3; i++) push(i);
    eq("R5", "below level", wmark_o, 0);
    push(3);
    eq("R5", "at level", wmark_o, 1);
    push(4);
    eq("R5", "above level", wmark_o, 1);
    pop();
    eq("R5", "back at level", wmark_o, 1);
    pop();
    eq("R5", "below after pop", wmark_o, 0);
    pop(); pop(); pop();
  endtask

  task automatic t_same_mode();
    push(7); push(8); push(9);
    cfg(M_FILL, 1'b0, 2);
    eq("R10", "count kept", count_o, 3);
    eq("R10", "data kept", data_o, 7);
    eq("R10", "new level used", wmark_o, 1);
    cfg(M_STRM, 1'b0, 2);
    eq("R9", "mode change clears", count_o, 0);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++) push(100 + i);
    eq("R4", "count full", count_o, 32);
    eq("R4", "oldest is newest-32", data_o, 108);
    eq("R6", "overrun in stream", overrun_o, 1);
    pop();
    eq("R4", "next oldest", data_o, 109);
    eq("R6", "pop clears overrun", overrun_o, 0);
  endtask

  task automatic t_simul();
    cfg(M_FILL, 1'b0, 0);
    eq("R5", "level 0 keeps wmark", wmark_o, 1);
    push(1); push(2); push(3);
    push_pop(4);
    eq("R12", "count unchanged", count_o, 3);
    eq("R12", "head advanced", data_o, 2);
    for (int i = 5; i <= 33; i++) push(i);
    eq("R12", "full", count_o, 32);
    push_pop(50);
    eq("R12", "full push+pop count", count_o, 32);
    eq("R12", "full push+pop head", data_o, 3);
    for (int k = 0; k < 31; k++) pop();
    eq("R12", "sample accepted at full", data_o, 50);
    eq("R12", "one left", count_o, 1);
  endtask

  task automatic t_trigger();
    int n;
    cfg(M_TRIG, 1'b1, 5);
    for (int i = 0; i < 20; i++) push(200 + i);
    eq("R7", "pre-trigger count", count_o, 20);
    trigger();
    eq("R8", "busy after trigger", busy_o, 1);
    eq("R7", "triggered", trig_done_o, 1);
    eq("R11", "routed to line 1", trig_irq_o, 2'b10);
    pop_i = 1'b1;
    n = 0;
    while (busy_o && n < 100) begin
      @(negedge clk_i);
      pop_i = 1'b0;
      n++;
    end
    eq("R8", "busy cycles", n, 15);
    eq("R8", "pop during busy ignored", count_o, 5);
    eq("R7", "newest n kept", data_o, 215);
    for (int i = 0; i < 31; i++) push(300 + i);
    eq("R7", "fill-and-stop after trigger", count_o, 32);
    eq("R7", "head unchanged", data_o, 215);
    eq("R6", "overrun after refill", overrun_o, 1);
    trigger();
    @(negedge clk_i);
    eq("R9", "second trigger no trim", busy_o, 0);
    eq("R9", "second trigger count", count_o, 32);
    cfg(M_BYP, 1'b1, 5);
    eq("R9", "bypass clears status", trig_done_o, 0);
    eq("R9", "bypass empties", count_o, 0);
    cfg(M_TRIG, 1'b0, 3);
    for (int i = 0; i < 10; i++) push(400 + i);
    trigger();
    n = 0;
    while (busy_o && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    eq("R9", "re-armed trim", count_o, 3);
    eq("R7", "re-armed head", data_o, 407);
    eq("R11", "routed to line 0", trig_irq_o, 2'b01);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bypass();
    t_fill();
    t_wmark();
    t_same_mode();
    t_stream();
    t_simul();
    t_trigger();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule